// File: doc/BRIEF.md
# Video Memory Write Queue with DMA Ordering

This block keeps account of transfers waiting to reach video memory and tells the CPU when it must wait. Requests arrive as pushes that carry a word count and three flags. They sit in a small circular queue. An external slot generator pulses `slot_grant` once for each memory access slot that the video side can spend on CPU or DMA traffic. Each grant retires one transfer of the entry at the head of the queue. The block moves no data and generates no addresses. It only models the timing of the queue.

A DMA that runs in the background always stays last in the queue, and CPU writes overtake it. Its transfers are also left out of the pending level, the count that drives the CPU write stall and the full and empty status bits. A CPU read is the exception: it waits until every entry has drained, background DMA included. A push into an empty queue starts to be served only after a fixed number of slots.

Top module: `vram_write_queue`

## Requirements
- R1: The queue holds DEPTH (default 8) requests. A push that arrives while all entries are occupied is ignored: the pending level and the DMA indication do not change.
- R2: A push with a count of zero is ignored and creates no entry.
- R3: `push_flags` bit 0 marks byte access, bit 1 marks background DMA and bit 2 marks foreground DMA. A word entry with count N is finished after N grants. A byte entry with count N is finished after 2N grants, and the pending level drops by one on every second of those grants.
- R4: After a push into an empty queue, the first START_LAT (default 4) grants retire nothing.
- R5: `pend_level` is the number of words still pending in entries that are not background DMA. `stat_full` is high when the level is 4 or more. `stat_empty` is high when the level is 0.
- R6: `cpu_wr_wait` is high exactly while the pending level is above 4.
- R7: A push without the background flag, made while the last entry is background DMA, is placed ahead of that entry. The background entry therefore retires last.
- R8: If the background DMA entry is the only entry and is being served when a CPU write is pushed, its remaining count is stored back into that entry. The write is served next, after which the DMA resumes with the count it had left.
- R9: After `rd_req`, `cpu_rd_wait` is high until the queue holds no entry at all, background DMA included. It falls in the same cycle as the queue becomes empty. A read made while the queue is empty causes no wait.
- R10: `dma_busy` is high while any entry flagged as background or foreground DMA is in the queue. It falls when the last such entry retires.
- R11: When the queue becomes empty, the pending level is zero and neither wait output is high. The same holds after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push a transfer request this cycle |
| push_count | input | CNT_W | Word count of the pushed request |
| push_flags | input | 3 | Flags: bit 0 byte, bit 1 background DMA, bit 2 foreground DMA |
| rd_req | input | 1 | CPU read request |
| slot_grant | input | 1 | One access slot is available this cycle |
| cpu_wr_wait | output | 1 | CPU write must wait |
| cpu_rd_wait | output | 1 | CPU read must wait |
| stat_full | output | 1 | Pending level is at least 4 |
| stat_empty | output | 1 | Pending level is zero |
| dma_busy | output | 1 | A DMA entry is queued |
| pend_level | output | CNT_W+$clog2(DEPTH)+1 | Pending words, background DMA excluded |

## Verification
The bench builds the block with its defaults: DEPTH 8, an 8-bit count, a start latency of 4 slots and a stall level of 4. With these values a handful of single-word pushes fills the queue, so the overflow push, the full and wait thresholds and the start latency can all be reached in a few dozen cycles. A vector table walks word and byte draining, the insertion of a write ahead of a background DMA, and a read that waits for the whole queue. Directed tests then cover reset, overflow, zero-count pushes, foreground DMA and preemption of a lone background DMA that is already running.

// File: rtl/vwq_pkg.sv
package vwq_pkg;
    // Request flags; bit 0 is byte access, bit 1 background DMA, bit 2 foreground DMA
    typedef struct packed {
        logic fg;
        logic bg;
        logic byt;
    } vwq_flags_t;
endpackage

// File: rtl/vwq_start_delay.sv
module vwq_start_delay #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic ready
);
    localparam int LW = $clog2(LAT + 2);

    logic [LW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = LW'(LAT);
        else if (tick && cnt_q != '0)
            cnt_d = cnt_q - LW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == '0);
endmodule

// File: rtl/vwq_level_status.sv
module vwq_level_status #(
    parameter int LVL_W = 12,
    parameter int STALL = 4
) (
    input  logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty,
    output logic             wr_wait
);
    localparam logic [LVL_W-1:0] STALL_L = LVL_W'(STALL);

    assign full    = level >= STALL_L;
    assign empty   = level == '0;
    assign wr_wait = level > STALL_L;
endmodule

// File: rtl/vram_write_queue.sv
module vram_write_queue
    import vwq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int CNT_W     = 8,
    parameter int START_LAT = 4,
    parameter int STALL     = 4,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int QL_W     = IDX_W + 1,
    localparam int LVL_W    = CNT_W + QL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [CNT_W-1:0] push_count,
    input  logic [2:0]       push_flags,
    input  logic             rd_req,
    input  logic             slot_grant,
    output logic             cpu_wr_wait,
    output logic             cpu_rd_wait,
    output logic             stat_full,
    output logic             stat_empty,
    output logic             dma_busy,
    output logic [LVL_W-1:0] pend_level
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        vwq_flags_t       flg;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
        logic [IDX_W-1:0]   qx;
        logic [QL_W-1:0]    ql;
        logic [CNT_W:0]     rem;
        logic [LVL_W-1:0]   level;
        logic [QL_W-1:0]    dmac;
        logic               rd_pend;
    } state_t;

    state_t q, d;
    logic   lat_ready;
    logic   lat_load;
    logic [QL_W-1:0] occ;

    function automatic logic [CNT_W:0] slots_of(entry_t e);
        return e.flg.byt ? {e.cnt, 1'b0} : {1'b0, e.cnt};
    endfunction

    always_comb begin
        entry_t           head, moved, newe;
        logic [IDX_W-1:0] tail;
        logic             accept;

        d        = q;
        lat_load = 1'b0;
        head     = q.ent[q.qx];
        newe     = '{cnt: push_count, flg: vwq_flags_t'(push_flags)};
        moved    = '0;
        tail     = '0;

        // one slot retires one transfer of the head entry
        if (slot_grant && q.ql != '0 && lat_ready) begin
            if (!head.flg.bg && (!head.flg.byt || q.rem[0]))
                d.level = d.level - LVL_W'(1);
            d.rem = q.rem - (CNT_W+1)'(1);
            if (q.rem == (CNT_W+1)'(1)) begin
                if (head.flg.bg || head.flg.fg)
                    d.dmac = d.dmac - QL_W'(1);
                d.qx = q.qx + IDX_W'(1);
                d.ql = q.ql - QL_W'(1);
                if (d.ql != '0) d.rem = slots_of(d.ent[d.qx]);
                else            d.level = '0;
            end
        end

        // enqueue, background DMA kept at the tail
        accept = push_valid && push_count != '0 && d.ql != QL_W'(DEPTH);
        if (accept) begin
            lat_load = (d.ql == '0);
            tail     = d.qx + IDX_W'(d.ql) - IDX_W'(1);
            if (d.ql != '0 && d.ent[tail].flg.bg && !newe.flg.bg) begin
                moved = d.ent[tail];
                if (d.ql == QL_W'(1)) begin
                    moved.cnt = CNT_W'(d.rem >> moved.flg.byt);
                    d.rem     = slots_of(newe);
                end
                d.ent[tail + IDX_W'(1)] = moved;
                d.ent[tail]             = newe;
            end else begin
                d.ent[d.qx + IDX_W'(d.ql)] = newe;
                if (d.ql == '0) d.rem = slots_of(newe);
            end
            d.ql = d.ql + QL_W'(1);
            if (!newe.flg.bg)
                d.level = d.level + LVL_W'(push_count);
            if (newe.flg.bg || newe.flg.fg)
                d.dmac = d.dmac + QL_W'(1);
        end

        // CPU read waits for a completely drained queue
        if (d.ql == '0)  d.rd_pend = 1'b0;
        else if (rd_req) d.rd_pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    vwq_start_delay #(.LAT(START_LAT)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (lat_load),
        .tick  (slot_grant),
        .ready (lat_ready)
    );

    vwq_level_status #(.LVL_W(LVL_W), .STALL(STALL)) u_status (
        .level   (q.level),
        .full    (stat_full),
        .empty   (stat_empty),
        .wr_wait (cpu_wr_wait)
    );

    assign occ         = q.ql;
    assign pend_level  = q.level;
    assign cpu_rd_wait = q.rd_pend;
    assign dma_busy    = q.dmac != '0;
endmodule

// File: rtl/vwq_checker.sv
module vwq_checker #(
    parameter int DEPTH = 8,
    parameter int QL_W  = 4,
    parameter int LVL_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_valid,
    input logic             rd_req,
    input logic             slot_grant,
    input logic             cpu_wr_wait,
    input logic             cpu_rd_wait,
    input logic             stat_full,
    input logic             stat_empty,
    input logic             dma_busy,
    input logic [LVL_W-1:0] pend_level,
    input logic [QL_W-1:0]  occ
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= QL_W'(DEPTH)); // R1
    AST_NO_GRANT_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_grant |=> occ >= $past(occ)); // R3
    AST_NO_PUSH_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !push_valid |=> pend_level <= $past(pend_level)); // R5
    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_full && stat_empty)); // R5
    AST_WAIT_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_wait |-> stat_full); // R6
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_wait && !slot_grant) |=> cpu_rd_wait); // R9
    AST_EMPTY_QUEUE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        occ == '0 |-> (pend_level == '0 && !cpu_rd_wait && !dma_busy)); // R11
    AST_BUSY_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        dma_busy |-> occ != '0); // R10
endmodule

bind vram_write_queue vwq_checker #(
    .DEPTH (DEPTH),
    .QL_W  (QL_W),
    .LVL_W (LVL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_valid  (push_valid),
    .rd_req      (rd_req),
    .slot_grant  (slot_grant),
    .cpu_wr_wait (cpu_wr_wait),
    .cpu_rd_wait (cpu_rd_wait),
    .stat_full   (stat_full),
    .stat_empty  (stat_empty),
    .dma_busy    (dma_busy),
    .pend_level  (pend_level),
    .occ         (occ)
);

// File: tb/tb_vram_write_queue.sv
`timescale 1ns/1ps
module tb_vram_write_queue;
    localparam int CNT_W = 8;
    localparam int LVL_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_valid = 1'b0;
    logic [CNT_W-1:0] push_count = '0;
    logic [2:0]       push_flags = '0;
    logic             rd_req = 1'b0;
    logic             slot_grant = 1'b0;
    logic             cpu_wr_wait, cpu_rd_wait, stat_full, stat_empty, dma_busy;
    logic [LVL_W-1:0] pend_level;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    vram_write_queue dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_count(push_count),
        .push_flags(push_flags), .rd_req(rd_req), .slot_grant(slot_grant),
        .cpu_wr_wait(cpu_wr_wait), .cpu_rd_wait(cpu_rd_wait), .stat_full(stat_full),
        .stat_empty(stat_empty), .dma_busy(dma_busy), .pend_level(pend_level)
    );

    typedef struct packed {
        logic       p;
        logic [7:0] c;
        logic [2:0] f;
        logic       g;
        logic       r;
        logic [7:0] lvl;
        logic       wr;
        logic       rw;
        logic       bz;
    } vec_t;

    // push, count, flags, grant, read | level, wr_wait, rd_wait, busy
    localparam vec_t VEC [30] = '{
        '{1'b1, 8'd3, 3'd0, 1'b0, 1'b0, 8'd3, 1'b0, 1'b0, 1'b0},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd3, 1'b0, 1'b0, 1'b0},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd3, 1'b0, 1'b0, 1'b0},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd3, 1'b0, 1'b0, 1'b0},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd3, 1'b0, 1'b0, 1'b0},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd2, 1'b0, 1'b0, 1'b0},
        '{1'b1, 8'd2, 3'd1, 1'b0, 1'b0, 8'd4, 1'b0, 1'b0, 1'b0},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd3, 1'b0, 1'b0, 1'b0},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd2, 1'b0, 1'b0, 1'b0},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd2, 1'b0, 1'b0, 1'b0},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd1, 1'b0, 1'b0, 1'b0},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd1, 1'b0, 1'b0, 1'b0},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 8'd5, 3'd0, 1'b0, 1'b0, 8'd5, 1'b1, 1'b0, 1'b0},
        '{1'b1, 8'd3, 3'd2, 1'b0, 1'b0, 8'd5, 1'b1, 1'b0, 1'b1},
        '{1'b1, 8'd1, 3'd0, 1'b0, 1'b0, 8'd6, 1'b1, 1'b0, 1'b1},
        '{1'b0, 8'd0, 3'd0, 1'b0, 1'b1, 8'd6, 1'b1, 1'b1, 1'b1},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd6, 1'b1, 1'b1, 1'b1},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd6, 1'b1, 1'b1, 1'b1},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd6, 1'b1, 1'b1, 1'b1},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd6, 1'b1, 1'b1, 1'b1},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd5, 1'b1, 1'b1, 1'b1},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd4, 1'b0, 1'b1, 1'b1},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd3, 1'b0, 1'b1, 1'b1},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd2, 1'b0, 1'b1, 1'b1},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd1, 1'b0, 1'b1, 1'b1},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd0, 1'b0, 1'b1, 1'b1},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd0, 1'b0, 1'b1, 1'b1},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd0, 1'b0, 1'b1, 1'b1},
        '{1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // entered at a falling edge; inputs held across one rising edge
    task automatic cyc(input bit p, input int c, input int f, input bit g, input bit r);
        push_valid = p;
        push_count = CNT_W'(c);
        push_flags = 3'(f);
        slot_grant = g;
        rd_req     = r;
        @(posedge clk);
        @(negedge clk);
        push_valid = 1'b0;
        push_count = '0;
        push_flags = '0;
        slot_grant = 1'b0;
        rd_req     = 1'b0;
    endtask

    task automatic grants(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, 0);
    endtask

    task automatic level_chk(input string tag, input int lvl);
        chk({tag, " level"}, int'(pend_level), lvl);
        chk({tag, " full"},  int'(stat_full),  int'(lvl >= 4));
        chk({tag, " empty"}, int'(stat_empty), int'(lvl == 0));
        chk({tag, " wr_wait"}, int'(cpu_wr_wait), int'(lvl > 4));
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        level_chk("R11 reset", 0);
        chk("R11 reset rd_wait", int'(cpu_rd_wait), 0);
        chk("R10 reset busy", int'(dma_busy), 0);

        // vector walk: R3 R4 R5 R6 R7 R9 R10
        for (int i = 0; i < 30; i++) begin
            cyc(VEC[i].p, int'(VEC[i].c), int'(VEC[i].f), VEC[i].g, VEC[i].r);
            level_chk($sformatf("R3/R4/R5/R6/R7 vec%0d", i), int'(VEC[i].lvl));
            chk($sformatf("R9 vec%0d rd_wait", i), int'(cpu_rd_wait), int'(VEC[i].rw));
            chk($sformatf("R10 vec%0d busy", i), int'(dma_busy), int'(VEC[i].bz));
        end

        // R9: read on empty queue does not wait
        cyc(0, 0, 0, 0, 1);
        chk("R9 empty read", int'(cpu_rd_wait), 0);

        // R2: zero count push ignored
        cyc(1, 0, 4, 0, 0);
        level_chk("R2 zero count", 0);
        chk("R2 zero count busy", int'(dma_busy), 0);

        // R1: overflow push ignored
        for (int i = 0; i < 8; i++) cyc(1, 1, 0, 0, 0);
        level_chk("R1 eight entries", 8);
        cyc(1, 1, 4, 0, 0);
        level_chk("R1 ninth push", 8);
        chk("R1 ninth push busy", int'(dma_busy), 0);
        grants(4);
        level_chk("R4 latency", 8);
        grants(7);
        level_chk("R1 drain", 1);
        grants(1);
        level_chk("R11 drained", 0);

        // R10: foreground DMA
        cyc(1, 2, 4, 0, 0);
        chk("R10 fg busy", int'(dma_busy), 1);
        level_chk("R10 fg level", 2);
        grants(5);
        chk("R10 fg busy mid", int'(dma_busy), 1);
        grants(1);
        chk("R10 fg done", int'(dma_busy), 0);
        level_chk("R10 fg done", 0);

        // R8: lone running background DMA preempted by a CPU write
        cyc(1, 6, 2, 0, 0);
        level_chk("R8 bg only", 0);
        grants(6);
        cyc(1, 2, 0, 0, 0);
        level_chk("R8 write in", 2);
        grants(1);
        level_chk("R8 write first", 1);
        grants(1);
        level_chk("R8 write done", 0);
        cyc(0, 0, 0, 0, 1);
        chk("R8 read waits for bg", int'(cpu_rd_wait), 1);
        grants(3);
        chk("R8 bg remaining", int'(cpu_rd_wait), 1);
        chk("R8 bg busy", int'(dma_busy), 1);
        grants(1);
        chk("R8 bg finished rd", int'(cpu_rd_wait), 0);
        chk("R8 bg finished busy", int'(dma_busy), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule